// File: doc/BRIEF.md
# Scan-Out Monochrome Cursor Overlay

This block sits in the pixel path of a display pipeline and draws a 64x64 two-plane monochrome pointer over the 32-bit pixels coming from the frame buffer. The timing generator pulses `line_load` during horizontal blanking, together with the index of the line about to be shown. If that line crosses the cursor, the block reads the 16 bitmap bytes of the matching cursor row through a byte-wide read port with a fixed latency, and keeps them in a small row buffer. Later, during the active part of the line, each pixel is decided from that buffer alone, without touching memory.

Each cursor pixel has one bit in a mask plane and one bit in a pattern plane. Together these two bits say whether the screen pixel is replaced by one of two programmable colours, inverted, or left alone. Pixels at or beyond the horizontal display width are never changed, so a cursor near the right edge is cut off rather than wrapping onto the next line. The output is registered, and the valid and sync strobes are delayed by the same cycle.

Top module: `cursor_overlay`

## Requirements
- R1: When `line_load` is pulsed for a line that is covered by the cursor, the block issues exactly 16 single-byte reads, one per cycle, starting on the cycle after the pulse, at consecutive addresses `cur_base + (load_y - y)*16 + k` for k = 0..15. Bytes 0..7 form the mask plane and bytes 8..15 form the pattern plane.
- R2: Within each bitmap byte, the most significant bit belongs to the leftmost pixel. Byte j covers cursor columns 8j to 8j+7.
- R3: A pixel whose mask bit is 1 and pattern bit is 1 is output as the bitwise inverse of all 32 bits of `pix_in`.
- R4: A pixel whose mask bit is 1 and pattern bit is 0 is output as `pix_in` unchanged.
- R5: A pixel whose mask bit is 0 is output as `{8'hFF, colour[23:0]}`. The colour is `color1` when the pattern bit is 1 and `color0` when it is 0. Bits 31:24 of both colour inputs are ignored.
- R6: A cursor pixel whose screen x is at or above `h_disp_end` is not drawn, and `pix_in` passes through unchanged.
- R7: While `cur_en` is 0, `pix_out` equals the `pix_in` of the previous cycle.
- R8: A line is not drawn when it is below y, above y+63, or greater than `v_disp_end`. Such a line causes no memory reads.
- R9: `cur_pos[31:16]` gives the cursor's left column and `cur_pos[15:0]` gives its top line. The cursor covers columns x..x+63.
- R10: `pix_out`, `pix_valid_out`, `hsync_out` and `vsync_out` are each one clock behind their inputs. After reset all outputs are 0.
- R11: The row buffer is complete 16 + MEM_LAT cycles after `line_load`. The active part of a line must start no earlier than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beam_x | input | COORD_W | Screen column of `pix_in` |
| pix_in | input | 32 | Underlying pixel |
| pix_valid_in | input | 1 | Pixel strobe, delayed only |
| hsync_in | input | 1 | Horizontal sync, delayed only |
| vsync_in | input | 1 | Vertical sync, delayed only |
| line_load | input | 1 | Pulse in blanking that starts a row fetch |
| load_y | input | COORD_W | Line about to be displayed |
| h_disp_end | input | COORD_W | Horizontal display width in pixels |
| v_disp_end | input | COORD_W | Last visible line |
| cur_en | input | 1 | Cursor enable |
| cur_pos | input | 32 | Cursor position: x in 31:16, y in 15:0 |
| cur_base | input | ADDR_W | Byte address of cursor row 0 |
| color0 | input | 32 | Colour for pattern bit 0 (bits 23:0 used) |
| color1 | input | 32 | Colour for pattern bit 1 (bits 23:0 used) |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rd_data | input | 8 | Read data, MEM_LAT cycles after the request |
| pix_out | output | 32 | Overlaid pixel |
| pix_valid_out | output | 1 | Delayed pixel strobe |
| hsync_out | output | 1 | Delayed horizontal sync |
| vsync_out | output | 1 | Delayed vertical sync |

## Verification
The bench sweeps every column of a 100-pixel line for every line from above the cursor to below it, in several position and clipping setups. The bitmap is a hashed byte pattern, so all four mask/pattern combinations appear at every bit position inside a byte. This tells a wrong bit order or a swapped plane apart from a correct overlay. One setup puts the cursor across the horizontal display end and sets the vertical display end inside the cursor, which separates clipping from the cursor's own bounds. A further pass with the enable cleared, and the colour inputs carrying junk in their top bytes, shows that the high colour bits and the disabled state leave no trace. Every fetch is also checked address by address, and the number of reads per line is counted.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 24,
  parameter int MEM_LAT = 2,
  parameter int CUR_DIM = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] beam_x,
  input  logic [31:0]        pix_in,
  input  logic               pix_valid_in,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic               line_load,
  input  logic [COORD_W-1:0] load_y,
  input  logic [COORD_W-1:0] h_disp_end,
  input  logic [COORD_W-1:0] v_disp_end,
  input  logic               cur_en,
  input  logic [31:0]        cur_pos,
  input  logic [ADDR_W-1:0]  cur_base,
  input  logic [31:0]        color0,
  input  logic [31:0]        color1,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [7:0]         mem_rd_data,
  output logic [31:0]        pix_out,
  output logic               pix_valid_out,
  output logic               hsync_out,
  output logic               vsync_out
);
  localparam int BYTES = CUR_DIM / 8;
  localparam int ROW_BYTES = 2 * BYTES;
  localparam int CNT_W = $clog2(ROW_BYTES);
  localparam int DX_W = $clog2(CUR_DIM);
  localparam logic [15:0] DIM16 = 16'(CUR_DIM);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROW_BYTES - 1);

  wire [15:0] cx = cur_pos[31:16];
  wire [15:0] cy = cur_pos[15:0];
  wire [15:0] ly = 16'(load_y);
  wire [15:0] row16 = ly - cy;
  wire vhit = cur_en && (ly >= cy) && (row16 < DIM16) && (ly <= 16'(v_disp_end));

  logic              busy, line_hit;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] row_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      line_hit <= 1'b0;
      cnt <= '0;
      row_addr <= '0;
    end else if (line_load) begin
      busy <= vhit;
      line_hit <= vhit;
      cnt <= '0;
      row_addr <= cur_base + ADDR_W'(row16[DX_W-1:0]) * ADDR_W'(ROW_BYTES);
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  assign mem_rd_en = busy;
  assign mem_addr  = row_addr + ADDR_W'(cnt);

  logic [MEM_LAT-1:0] rv;
  logic [CNT_W-1:0]   ridx [MEM_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv <= '0;
      for (int k = 0; k < MEM_LAT; k++) ridx[k] <= '0;
    end else begin
      rv[0] <= busy;
      ridx[0] <= cnt;
      for (int k = 1; k < MEM_LAT; k++) begin
        rv[k] <= rv[k-1];
        ridx[k] <= ridx[k-1];
      end
    end
  end

  logic [CUR_DIM-1:0] mask_row, pat_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_row <= '0;
      pat_row <= '0;
    end else if (rv[MEM_LAT-1]) begin
      for (int b = 0; b < BYTES; b++) begin
        if (ridx[MEM_LAT-1] == CNT_W'(b))
          mask_row[CUR_DIM-1-8*b -: 8] <= mem_rd_data;
        if (ridx[MEM_LAT-1] == CNT_W'(b + BYTES))
          pat_row[CUR_DIM-1-8*b -: 8] <= mem_rd_data;
      end
    end
  end

  wire [15:0] bx = 16'(beam_x);
  wire [15:0] dx16 = bx - cx;
  wire [DX_W-1:0] bsel = DX_W'(CUR_DIM - 1) - dx16[DX_W-1:0];
  wire in_cur = cur_en && line_hit && (bx >= cx) && (dx16 < DIM16) && (beam_x < h_disp_end);
  wire m_bit = mask_row[bsel];
  wire p_bit = pat_row[bsel];

  logic [31:0] ov;
  always_comb begin
    if (!in_cur)    ov = pix_in;
    else if (m_bit) ov = p_bit ? ~pix_in : pix_in;
    else            ov = {8'hFF, p_bit ? color1[23:0] : color0[23:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out <= '0;
      pix_valid_out <= 1'b0;
      hsync_out <= 1'b0;
      vsync_out <= 1'b0;
    end else begin
      pix_out <= ov;
      pix_valid_out <= pix_valid_in;
      hsync_out <= hsync_in;
      vsync_out <= vsync_in;
    end
  end
endmodule

module cursor_overlay_chk #(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cur_en,
  input logic               line_load,
  input logic [COORD_W-1:0] beam_x,
  input logic [COORD_W-1:0] h_disp_end,
  input logic [31:0]        pix_in,
  input logic [31:0]        pix_out,
  input logic               pix_valid_in,
  input logic               pix_valid_out,
  input logic               hsync_in,
  input logic               hsync_out,
  input logic               vsync_in,
  input logic               vsync_out,
  input logic               mem_rd_en,
  input logic [ADDR_W-1:0]  mem_addr
);
  // R7
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_en |=> pix_out == $past(pix_in));

  // R6
  hclip_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_x >= h_disp_end) |=> pix_out == $past(pix_in));

  // R10
  strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pix_valid_out == $past(pix_valid_in)) && (hsync_out == $past(hsync_in))
             && (vsync_out == $past(vsync_in)));

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en) && !$past(line_load)) |-> mem_addr == $past(mem_addr) + 1'b1);
endmodule

bind cursor_overlay cursor_overlay_chk #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  localparam int CW = 12;
  localparam int AW = 24;
  localparam int LAT = 2;
  localparam int HTOT = 100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [CW-1:0] beam_x = '0, load_y = '0, h_disp_end = '0, v_disp_end = '0;
  logic [31:0] pix_in = '0, cur_pos = '0, color0 = '0, color1 = '0;
  logic pix_valid_in = 0, hsync_in = 0, vsync_in = 0, line_load = 0, cur_en = 0;
  logic [AW-1:0] cur_base = '0;
  logic mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rd_data;
  logic [31:0] pix_out;
  logic pix_valid_out, hsync_out, vsync_out;

  cursor_overlay #(.COORD_W(CW), .ADDR_W(AW), .MEM_LAT(LAT)) dut (.*);

  logic [7:0] mem [2048];
  logic [7:0] pipe [LAT];
  always @(posedge clk) begin
    pipe[0] <= mem_rd_en ? mem[mem_addr[10:0]] : 8'h00;
    for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
  end
  assign mem_rd_data = pipe[LAT-1];

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int cx(); return int'(cur_pos[31:16]); endfunction
  function automatic int cy(); return int'(cur_pos[15:0]); endfunction

  function automatic bit line_on(int y);
    return cur_en && y >= cy() && y < cy() + 64 && y <= int'(v_disp_end);
  endfunction

  function automatic logic [31:0] pin_of(int x, int y);
    return {8'(x) ^ 8'h96, 8'(y), 8'(x * 3), 8'hC3};
  endfunction

  task automatic expect_pix(input int x, input int y, input logic [31:0] pin,
                            output logic [31:0] e, output string tag);
    int dx, a_byte, p_byte;
    bit m, p;
    e = pin;
    dx = x - cx();
    if (!cur_en) tag = "R7";
    else if (!line_on(y)) tag = "R8";
    else if (dx < 0 || dx >= 64) tag = "R9";
    else if (x >= int'(h_disp_end)) tag = "R6";
    else begin
      a_byte = int'(cur_base) + (y - cy()) * 16 + dx / 8;
      p_byte = a_byte + 8;
      m = mem[a_byte][7 - dx % 8];
      p = mem[p_byte][7 - dx % 8];
      if (m && p) begin e = ~pin; tag = "R2+R3"; end
      else if (m) begin e = pin; tag = "R2+R4"; end
      else begin
        e = {8'hFF, p ? color1[23:0] : color0[23:0]};
        tag = "R2+R5";
      end
    end
  endtask

  task automatic load_line(input int y);
    int n = 0;
    int row = y - cy();
    beam_x = CW'(HTOT); pix_valid_in = 0;
    @(negedge clk);
    load_y = CW'(y); line_load = 1;
    for (int k = 0; k < 16 + LAT + 4; k++) begin
      @(negedge clk);
      line_load = 0;
      if (mem_rd_en) begin
        chk(mem_addr == AW'(int'(cur_base) + row * 16 + n), "R1", 32'(mem_addr),
            32'(int'(cur_base) + row * 16 + n));
        n++;
      end
    end
    // R11 R8
    chk(n == (line_on(y) ? 16 : 0), line_on(y) ? "R11" : "R8", 32'(n), line_on(y) ? 32'd16 : 32'd0);
  endtask

  task automatic sweep_line(input int y);
    logic [31:0] pp, e;
    bit pv, ph;
    string tag;
    for (int x = 0; x <= HTOT; x++) begin
      @(negedge clk);
      if (x > 0) begin
        expect_pix(x - 1, y, pp, e, tag);
        chk(pix_out === e, tag, pix_out, e);
        chk(pix_valid_out === pv && hsync_out === ph, "R10",
            {30'd0, pix_valid_out, hsync_out}, {30'd0, pv, ph});
      end
      if (x < HTOT) begin
        pp = pin_of(x, y);
        pv = (x < int'(h_disp_end));
        ph = (x >= HTOT - 8);
        beam_x = CW'(x); pix_in = pp; pix_valid_in = pv; hsync_in = ph; vsync_in = y[0];
      end
    end
  endtask

  task automatic run_lines(input int y0, input int y1);
    for (int y = y0; y <= y1; y++) begin
      load_line(y);
      sweep_line(y);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 73 + 29) ^ (i >> 3));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(pix_out === 32'd0 && pix_valid_out === 1'b0 && mem_rd_en === 1'b0, "R10",
        pix_out, 32'd0);
    rst_n = 1;

    cur_en = 1; cur_pos = {16'd10, 16'd5}; cur_base = AW'('h100);
    h_disp_end = CW'(80); v_disp_end = CW'(200);
    color0 = 32'hA5123456; color1 = 32'h5A89ABCD;
    run_lines(0, 71);

    cur_pos = {16'd50, 16'd2}; cur_base = AW'('h240); v_disp_end = CW'(30);
    color0 = 32'hFF00FF00; color1 = 32'h33C0FFEE;
    run_lines(0, 34);

    cur_en = 0; cur_pos = {16'd10, 16'd5};
    run_lines(5, 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule